// File: doc/BRIEF.md
# Dual-Slot SD Card SPI Byte Engine

This block moves single bytes between a local processor and one of two SD card sockets over SPI. Both sockets hang on one shared serial clock, one shared data-out line and one shared data-in line. Each socket has its own active-low chip select. The processor drives a small register interface. Writing the data register while the engine is idle starts an 8-bit full-duplex exchange. The processor then polls a busy flag and reads the received byte once the flag drops.

A control register sets two things. The first is which socket is selected. The second is whether the serial clock runs at the slow card-initialization rate (about 400 kHz) or the fast data rate (about 2 MHz). Both rates come from dividing the system clock by parameters. The engine latches the chosen rate at the start of each byte, so a rate change always takes effect between bytes.

The status register shows the busy flag and the two card-present inputs. Each card-present input first passes through its own synchronizer. Command framing, CRC and sector buffering are left to software.

Top module: `sd_dual_spi_master`

## Requirements
- R1: After reset both chip selects are high, the serial clock is low, data-out is high, the busy flag (status bit 0) is 0 and the data register reads 0x00.
- R2: A write to address 0 while idle starts an exchange in SPI mode 0, most significant bit first. The serial clock idles low. Data-out is valid before each rising clock edge and changes only while the clock is low. Exactly 8 rising edges occur.
- R3: Data-in is sampled on each rising serial clock edge, most significant bit first. Once busy clears, address 0 reads the received byte.
- R4: A write to address 0 while busy is ignored. The transmitted byte is unchanged and no extra clock edges are produced.
- R5: Each serial clock half period lasts SLOW_HALF system cycles when control bit 2 is 0, and FAST_HALF cycles when it is 1. The rate is latched when a byte starts, so changing bit 2 during a byte leaves that byte's rate unchanged.
- R6: Control bit 0 requests slot A and bit 1 requests slot B. The chip selects are active low. When both bits are set, only slot A is selected.
- R7: The card-present inputs appear in status bit 1 (slot A) and status bit 2 (slot B) two clock edges after they change, and not before.
- R8: Data-out is high whenever no exchange is in progress, including right after a byte whose last bit was 0.
- R9: Address 1 reads back the three control bits as last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register address: 0 data, 1 control, 2 status |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| card_in_a | input | 1 | Slot A card-present, high when a card is inserted (asynchronous) |
| card_in_b | input | 1 | Slot B card-present, high when a card is inserted (asynchronous) |
| spi_sclk | output | 1 | Shared serial clock |
| spi_mosi | output | 1 | Shared serial data out |
| spi_miso | input | 1 | Shared serial data in |
| spi_cs_a_n | output | 1 | Slot A chip select, active low |
| spi_cs_b_n | output | 1 | Slot B chip select, active low |

## Verification
The hardest case to reach from the ports is a change of the rate bit partway through a byte. The engine must keep the latched rate until that byte ends and only then switch. The bench starts a slow byte and rewrites the control register to the fast rate a few cycles later. It then counts the system cycles during which the serial clock is high, for both that byte and the next one. A second directed case writes a new byte while busy and counts clock edges to show the write had no effect. These cases run alongside seeded random bytes that mix both rates and random reply data from a modelled card.

// File: rtl/sdspi_pkg.sv
package sdspi_pkg;

   localparam int REG_AW = 2;

   localparam logic [REG_AW-1:0] ADDR_DATA   = 2'd0;
   localparam logic [REG_AW-1:0] ADDR_CTRL   = 2'd1;
   localparam logic [REG_AW-1:0] ADDR_STATUS = 2'd2;

   typedef struct packed {
      logic fast;
      logic sel_b;
      logic sel_a;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/sdspi_sync.sv
module sdspi_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   generate
      if (STAGES < 2) begin : g_bad
         $error("sdspi_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= '0;
               else        chain[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/sdspi_rate_gen.sv
module sdspi_rate_gen #(
   parameter int SLOW_HALF = 156,
   parameter int FAST_HALF = 31
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic fast_req,
   input  logic run,
   output logic tick
);

   localparam int CNT_W = (SLOW_HALF > 1) ? $clog2(SLOW_HALF) : 1;
   localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_HALF - 1);
   localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_HALF - 1);

   generate
      if (FAST_HALF < 1 || SLOW_HALF < FAST_HALF) begin : g_bad
         $error("sdspi_rate_gen: need 1 <= FAST_HALF <= SLOW_HALF");
      end
   endgenerate

   logic             fast_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last;

   assign last = fast_q ? FAST_LAST : SLOW_LAST;
   assign tick = run && !load && (cnt_q == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fast_q <= 1'b0;
         cnt_q  <= '0;
      end else if (load) begin
         fast_q <= fast_req;
         cnt_q  <= '0;
      end else if (run) begin
         if (cnt_q == last) cnt_q <= '0;
         else               cnt_q <= cnt_q + 1'b1;
      end else begin
         cnt_q <= '0;
      end
   end

endmodule

// File: rtl/sdspi_shifter.sv
module sdspi_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              tick,
   input  logic              miso,
   output logic              sclk,
   output logic              mosi,
   output logic              busy,
   output logic [DATA_W-1:0] rx_byte
);

   localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

   logic [DATA_W-1:0] sh_q;
   logic [BIT_W-1:0]  bit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         sclk    <= 1'b0;
         mosi    <= 1'b1;
         sh_q    <= '0;
         bit_q   <= '0;
         rx_byte <= '0;
      end else if (start) begin
         busy  <= 1'b1;
         sclk  <= 1'b0;
         sh_q  <= tx_byte;
         mosi  <= tx_byte[DATA_W-1];
         bit_q <= '0;
      end else if (busy && tick) begin
         if (!sclk) begin
            sclk <= 1'b1;
            sh_q <= {sh_q[DATA_W-2:0], miso};
         end else begin
            sclk <= 1'b0;
            if (bit_q == LAST_BIT) begin
               busy    <= 1'b0;
               rx_byte <= sh_q;
               mosi    <= 1'b1;
            end else begin
               bit_q <= bit_q + 1'b1;
               mosi  <= sh_q[DATA_W-1];
            end
         end
      end
   end

   p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(mosi));

   p_idle_lines_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (mosi && !sclk));

endmodule

// File: rtl/sd_dual_spi_master.sv
module sd_dual_spi_master
   import sdspi_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SLOW_HALF   = 156,
   parameter int FAST_HALF   = 31,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              card_in_a,
   input  logic              card_in_b,
   output logic              spi_sclk,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic              spi_cs_a_n,
   output logic              spi_cs_b_n
);

   generate
      if (DATA_W < CTRL_W || DATA_W < 3) begin : g_bad
         $error("sd_dual_spi_master: DATA_W too narrow for the register map");
      end
   endgenerate

   ctrl_t             ctrl_q;
   logic              busy;
   logic              tick;
   logic              start;
   logic [DATA_W-1:0] rx_byte;
   logic [1:0]        present;

   assign start = reg_wr && (reg_addr == ADDR_DATA) && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 ctrl_q <= '0;
      else if (reg_wr && reg_addr == ADDR_CTRL)   ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
   end

   assign spi_cs_a_n = ~ctrl_q.sel_a;
   assign spi_cs_b_n = ~(ctrl_q.sel_b & ~ctrl_q.sel_a);

   sdspi_rate_gen #(
      .SLOW_HALF (SLOW_HALF),
      .FAST_HALF (FAST_HALF)
   ) u_rate (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start),
      .fast_req (ctrl_q.fast),
      .run      (busy),
      .tick     (tick)
   );

   sdspi_shifter #(
      .DATA_W (DATA_W)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .tx_byte (reg_wdata),
      .tick    (tick),
      .miso    (spi_miso),
      .sclk    (spi_sclk),
      .mosi    (spi_mosi),
      .busy    (busy),
      .rx_byte (rx_byte)
   );

   sdspi_sync #(
      .WIDTH  (2),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in ({card_in_b, card_in_a}),
      .sync_out (present)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_DATA:   reg_rdata = rx_byte;
         ADDR_CTRL:   reg_rdata[CTRL_W-1:0] = ctrl_q;
         ADDR_STATUS: reg_rdata[2:0] = {present[1], present[0], busy};
         default:     reg_rdata = '0;
      endcase
   end

   p_cs_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({~spi_cs_a_n, ~spi_cs_b_n}));

   p_start_on_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(reg_wr && reg_addr == ADDR_DATA));

   p_ignore_busy_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_wr && reg_addr == ADDR_DATA && !spi_sclk) |=> !$rose(spi_sclk) || $past(tick));

endmodule

// File: tb/tb_sd_dual_spi_master.sv
module tb_sd_dual_spi_master;

   localparam int SLOW = 156;
   localparam int FAST = 31;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_addr = '0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       card_in_a = 1'b0, card_in_b = 1'b0;
   logic       spi_sclk, spi_mosi, spi_miso, spi_cs_a_n, spi_cs_b_n;

   int checks = 0;
   int failures = 0;
   bit done_flag = 0;

   always #4 clk = ~clk;

   sd_dual_spi_master #(.SLOW_HALF(SLOW), .FAST_HALF(FAST)) dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .card_in_a(card_in_a), .card_in_b(card_in_b),
      .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
      .spi_cs_a_n(spi_cs_a_n), .spi_cs_b_n(spi_cs_b_n));

   // card model: shifts reply out on falling clock, captures data-out on rising
   logic [7:0] slave_sh = 8'h00;
   logic [7:0] captured = 8'h00;
   int         rises = 0;
   int         high_cycles = 0;

   assign spi_miso = slave_sh[7];
   always @(posedge spi_sclk) begin
      captured <= {captured[6:0], spi_mosi};
      rises    <= rises + 1;
   end
   always @(negedge spi_sclk) slave_sh <= {slave_sh[6:0], 1'b0};
   always @(posedge clk) if (spi_sclk) high_cycles <= high_cycles + 1;

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_idle();
      logic [7:0] st;
      for (int i = 0; i < 20000; i++) begin
         bus_read(2'd2, st);
         if (!st[0]) return;
      end
      check("R3 busy never cleared", 1, 0);
   endtask

   function automatic int expect_high(input bit fast);
      return 8 * (fast ? FAST : SLOW);
   endfunction

   task automatic xfer(input logic [7:0] tx, input logic [7:0] reply,
                       input bit fast, input string tag);
      logic [7:0] rx;
      bus_write(2'd1, {5'd0, fast, 2'b01});
      @(negedge clk);
      slave_sh = reply; rises = 0; high_cycles = 0;
      bus_write(2'd0, tx);
      wait_idle();
      bus_read(2'd0, rx);
      check({tag, " R2 mosi byte"}, captured, tx);
      check({tag, " R2 rising edges"}, rises, 8);
      check({tag, " R3 rx byte"}, rx, reply);
      check({tag, " R5 sclk high cycles"}, high_cycles, expect_high(fast));
   endtask

   initial begin
      #(8 * 200000);
      if (!done_flag) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      void'($urandom(32'h5D1C));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 cs_a_n", spi_cs_a_n, 1);
      check("R1 cs_b_n", spi_cs_b_n, 1);
      check("R1 sclk", spi_sclk, 0);
      check("R1 mosi", spi_mosi, 1);
      bus_read(2'd2, d); check("R1 busy", d[0], 0);
      bus_read(2'd0, d); check("R1 data", d, 8'h00);

      // R6 / R9 chip selects and control readback
      bus_write(2'd1, 8'h03); #1;
      check("R6 both req cs_a_n", spi_cs_a_n, 0);
      check("R6 both req cs_b_n", spi_cs_b_n, 1);
      bus_read(2'd1, d); check("R9 ctrl readback", d, 8'h03);
      bus_write(2'd1, 8'h06); #1;
      check("R6 b only cs_a_n", spi_cs_a_n, 1);
      check("R6 b only cs_b_n", spi_cs_b_n, 0);
      bus_read(2'd1, d); check("R9 ctrl readback", d, 8'h06);
      bus_write(2'd1, 8'h00); #1;
      check("R6 none cs_a_n", spi_cs_a_n, 1);
      check("R6 none cs_b_n", spi_cs_b_n, 1);

      // R7 synchronizer delay
      @(negedge clk); card_in_a = 1'b1; reg_addr = 2'd2;
      @(negedge clk); #1 check("R7 a after one edge", reg_rdata[1], 0);
      @(negedge clk); #1 check("R7 a after two edges", reg_rdata[1], 1);
      card_in_b = 1'b1;
      @(negedge clk); #1 check("R7 b after one edge", reg_rdata[2], 0);
      @(negedge clk); #1 check("R7 b after two edges", reg_rdata[2], 1);
      check("R7 a still present", reg_rdata[1], 1);

      // directed bytes, both rates; R8 after trailing zero
      xfer(8'h00, 8'hFF, 1'b1, "dir0");
      #1 check("R8 mosi idle high", spi_mosi, 1);
      xfer(8'hFF, 8'h00, 1'b0, "dir1");
      xfer(8'h81, 8'h7E, 1'b1, "dir2");

      // R4 write while busy ignored
      bus_write(2'd1, 8'h05);
      @(negedge clk); slave_sh = 8'hC3; rises = 0; high_cycles = 0;
      bus_write(2'd0, 8'hA5);
      repeat (40) @(negedge clk);
      bus_write(2'd0, 8'h3C);
      wait_idle();
      repeat (100) @(negedge clk);
      check("R4 mosi byte", captured, 8'hA5);
      check("R4 rising edges", rises, 8);
      bus_read(2'd0, d); check("R4 rx byte", d, 8'hC3);
      bus_read(2'd2, d); check("R4 busy after", d[0], 0);

      // R5 rate change mid-byte takes effect only at next byte
      bus_write(2'd1, 8'h01);
      @(negedge clk); slave_sh = 8'h5A; rises = 0; high_cycles = 0;
      bus_write(2'd0, 8'h96);
      repeat (20) @(negedge clk);
      bus_write(2'd1, 8'h05);
      wait_idle();
      check("R5 mid-change byte stays slow", high_cycles, expect_high(1'b0));
      @(negedge clk); rises = 0; high_cycles = 0;
      bus_write(2'd0, 8'h11);
      wait_idle();
      check("R5 next byte fast", high_cycles, expect_high(1'b1));

      // random bytes
      for (int n = 0; n < 24; n++) begin
         logic [7:0] t, r;
         bit f;
         t = 8'($urandom);
         r = 8'($urandom);
         f = ($urandom % 4) != 0;
         xfer(t, r, f, "rand");
         #1 check("R8 mosi idle high", spi_mosi, 1);
      end

      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule